// File: doc/BRIEF.md
# Bridge Address Window Forwarding Filter

This block decides, for every address phase that appears on either side of a two-port bus bridge, whether the bridge claims that cycle and passes it across. Two windows are held in programmable registers: one contiguous memory range and one contiguous I/O range. Together they describe the address space that lives behind the bridge on its downstream side. The upstream port claims cycles that fall inside a window. The downstream port claims cycles that fall outside the windows. 64-bit dual-address memory cycles follow a fixed routing rule on each port.

Three kinds of address are decoded: 32-bit memory addresses carried in one phase, 64-bit memory addresses carried in two consecutive phases (low word first), and 16-bit I/O addresses. Configuration cycles are decoded separately elsewhere and never produce a decision here. Each port has its own registered result: a strobe, a claim bit, a space tag and the assembled address. The result appears in the clock cycle after the last address phase of the cycle.

Top module: `bwf_filter`

## Requirements
- R1: After reset no result strobe is asserted and both windows are unarmed. With unarmed windows the upstream port claims no cycle, and the downstream port claims every single-phase memory and I/O cycle.
- R2: On the upstream port a single-phase memory cycle (kind 0) is claimed exactly when the memory window is armed and mem_base <= address <= mem_limit. Both ends are inclusive.
- R3: On the upstream port an I/O cycle (kind 2) is claimed exactly when the I/O window is armed and io_base <= address[15:0] <= io_limit. Address bits 31:16 have no effect on the decision and are reported as zero.
- R4: On the downstream port a single-phase memory or I/O cycle is claimed exactly when its address does not match the corresponding window under the rules of R2 and R3.
- R5: A dual-address cycle starts with a phase of kind 1 carrying the low word. The next phase with the valid input high carries the high word, and its kind is ignored. No strobe follows the first phase. One cycle after the second phase the upstream port reports claim 0 and the downstream port reports claim 1, with the 64-bit address {high, low}.
- R6: A window whose limit is below its base matches no address. The upstream port then claims nothing in that space, and the downstream port claims everything in it.
- R7: A configuration cycle (kind 3) produces no result strobe on either port.
- R8: The result strobe is high for exactly the one cycle after the final address phase. It comes with the claim bit, the space tag (1 = I/O, 0 = memory) and the address: the memory address zero-extended, or the I/O address in bits 15:0.
- R9: A write with cfg_we high loads the register chosen by cfg_sel: 0 memory base, 1 memory limit, 2 I/O base (cfg_wdata[15:0]), 3 I/O limit (cfg_wdata[15:0]). Writing a limit arms its window. The new value governs decisions from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Window register write enable |
| cfg_sel | input | 2 | Window register select (R9) |
| cfg_wdata | input | 32 | Window register write data |
| up_vld | input | 1 | Upstream address phase valid |
| up_kind | input | 2 | Upstream cycle kind: 0 mem32, 1 dual-address, 2 I/O, 3 config |
| up_addr | input | 32 | Upstream address phase value |
| dn_vld | input | 1 | Downstream address phase valid |
| dn_kind | input | 2 | Downstream cycle kind, same encoding |
| dn_addr | input | 32 | Downstream address phase value |
| up_fwd_vld | output | 1 | Upstream decision strobe |
| up_fwd_claim | output | 1 | Upstream claims and forwards downstream |
| up_fwd_io | output | 1 | Upstream decision space tag, 1 = I/O |
| up_fwd_addr | output | 64 | Upstream assembled address |
| dn_fwd_vld | output | 1 | Downstream decision strobe |
| dn_fwd_claim | output | 1 | Downstream claims and forwards upstream |
| dn_fwd_io | output | 1 | Downstream decision space tag, 1 = I/O |
| dn_fwd_addr | output | 64 | Downstream assembled address |

## Verification
A corrupted window register shows up as a wrong claim bit on the first address that crosses the affected boundary. So the sweeps step one address at a time across each base and each limit, and check the decision in the cycle after each phase. A stuck or lost pending flag for a dual-address cycle shows up as a strobe after the first phase, or as a wrong high word, by the second cycle at the latest. Because both ports see the same address, a polarity fault on one port appears as the two claim bits being equal.

// File: rtl/bwf_pkg.sv
package bwf_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned IO_W   = 16;
  localparam int unsigned FULL_W = 2 * ADDR_W;

  typedef enum logic [1:0] {
    K_MEM = 2'd0,
    K_DAC = 2'd1,
    K_IO  = 2'd2,
    K_CFG = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    S_MBASE  = 2'd0,
    S_MLIM   = 2'd1,
    S_IOBASE = 2'd2,
    S_IOLIM  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] mem_base;
    logic [ADDR_W-1:0] mem_lim;
    logic [IO_W-1:0]   io_base;
    logic [IO_W-1:0]   io_lim;
    logic              mem_on;
    logic              io_on;
  } win_t;
endpackage

// File: rtl/bwf_window_regs.sv
module bwf_window_regs
  import bwf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output win_t              win
);
  win_t win_q, win_d;

  always_comb begin
    win_d = win_q;
    unique case (reg_sel_e'(sel))
      S_MBASE:  win_d.mem_base = wdata;
      S_MLIM: begin
        win_d.mem_lim = wdata;
        win_d.mem_on  = 1'b1;
      end
      S_IOBASE: win_d.io_base = wdata[IO_W-1:0];
      S_IOLIM: begin
        win_d.io_lim = wdata[IO_W-1:0];
        win_d.io_on  = 1'b1;
      end
      default:  win_d = win_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (we) begin
      win_q <= win_d;
    end
  end

  assign win = win_q;
endmodule

// File: rtl/bwf_range_cmp.sv
module bwf_range_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic         armed,
  output logic         hit
);
  logic above_lo;
  logic below_hi;

  assign above_lo = (val >= lo);
  assign below_hi = (val <= hi);
  // an inverted window (hi < lo) can never satisfy both terms
  assign hit      = armed && above_lo && below_hi;
endmodule

// File: rtl/bwf_port_decode.sv
module bwf_port_decode
  import bwf_pkg::*;
#(
  parameter bit DOWNSTREAM = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  win_t              win,
  output logic              fwd_vld,
  output logic              fwd_claim,
  output logic              fwd_io,
  output logic [FULL_W-1:0] fwd_addr
);
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] low_q, low_d;
  logic              ov_q, ov_d;
  logic              claim_q, claim_d;
  logic              io_q, io_d;
  logic [FULL_W-1:0] addr_q, addr_d;
  logic              hit_mem, hit_io;
  logic              low_en;

  bwf_range_cmp #(.W(ADDR_W)) i_mem_cmp (
    .val(addr), .lo(win.mem_base), .hi(win.mem_lim),
    .armed(win.mem_on), .hit(hit_mem)
  );

  bwf_range_cmp #(.W(IO_W)) i_io_cmp (
    .val(addr[IO_W-1:0]), .lo(win.io_base), .hi(win.io_lim),
    .armed(win.io_on), .hit(hit_io)
  );

  // next-state logic
  always_comb begin
    pend_d  = pend_q;
    low_d   = low_q;
    low_en  = 1'b0;
    ov_d    = 1'b0;
    claim_d = 1'b0;
    io_d    = 1'b0;
    addr_d  = addr_q;
    if (vld && pend_q) begin
      pend_d  = 1'b0;
      ov_d    = 1'b1;
      claim_d = DOWNSTREAM;
      addr_d  = {addr, low_q};
    end else if (vld) begin
      unique case (cyc_kind_e'(kind))
        K_MEM: begin
          ov_d    = 1'b1;
          claim_d = DOWNSTREAM ? !hit_mem : hit_mem;
          addr_d  = {{(FULL_W-ADDR_W){1'b0}}, addr};
        end
        K_DAC: begin
          pend_d = 1'b1;
          low_d  = addr;
          low_en = 1'b1;
        end
        K_IO: begin
          ov_d    = 1'b1;
          io_d    = 1'b1;
          claim_d = DOWNSTREAM ? !hit_io : hit_io;
          addr_d  = {{(FULL_W-IO_W){1'b0}}, addr[IO_W-1:0]};
        end
        default: ov_d = 1'b0;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      ov_q    <= 1'b0;
      claim_q <= 1'b0;
      io_q    <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      ov_q    <= ov_d;
      claim_q <= claim_d;
      io_q    <= io_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (low_en) begin
      low_q <= low_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (ov_d) begin
      addr_q <= addr_d;
    end
  end

  assign fwd_vld   = ov_q;
  assign fwd_claim = claim_q;
  assign fwd_io    = io_q;
  assign fwd_addr  = addr_q;
endmodule

// File: rtl/bwf_filter.sv
module bwf_filter
  import bwf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              up_vld,
  input  logic [1:0]        up_kind,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              dn_vld,
  input  logic [1:0]        dn_kind,
  input  logic [ADDR_W-1:0] dn_addr,
  output logic              up_fwd_vld,
  output logic              up_fwd_claim,
  output logic              up_fwd_io,
  output logic [FULL_W-1:0] up_fwd_addr,
  output logic              dn_fwd_vld,
  output logic              dn_fwd_claim,
  output logic              dn_fwd_io,
  output logic [FULL_W-1:0] dn_fwd_addr
);
  localparam int unsigned NPORT = 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  win_t win;

  bwf_window_regs i_regs (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .win(win)
  );

  logic [NPORT-1:0]             vld_a;
  logic [NPORT-1:0][1:0]        kind_a;
  logic [NPORT-1:0][ADDR_W-1:0] addr_a;
  logic [NPORT-1:0]             ov_a, claim_a, io_a;
  logic [NPORT-1:0][FULL_W-1:0] oaddr_a;

  assign vld_a  = {dn_vld, up_vld};
  assign kind_a = {dn_kind, up_kind};
  assign addr_a = {dn_addr, up_addr};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    bwf_port_decode #(.DOWNSTREAM(p == 1)) i_dec (
      .clk(clk), .rst_n(rst_int_n),
      .vld(vld_a[p]), .kind(kind_a[p]), .addr(addr_a[p]), .win(win),
      .fwd_vld(ov_a[p]), .fwd_claim(claim_a[p]), .fwd_io(io_a[p]),
      .fwd_addr(oaddr_a[p])
    );
  end

  assign up_fwd_vld   = ov_a[0];
  assign up_fwd_claim = claim_a[0];
  assign up_fwd_io    = io_a[0];
  assign up_fwd_addr  = oaddr_a[0];
  assign dn_fwd_vld   = ov_a[1];
  assign dn_fwd_claim = claim_a[1];
  assign dn_fwd_io    = io_a[1];
  assign dn_fwd_addr  = oaddr_a[1];
endmodule

// File: rtl/bwf_filter_chk.sv
module bwf_filter_chk
  import bwf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              up_vld,
  input logic              dn_vld,
  input logic              up_fwd_vld,
  input logic              up_fwd_claim,
  input logic              up_fwd_io,
  input logic [FULL_W-1:0] up_fwd_addr,
  input logic              dn_fwd_vld,
  input logic              dn_fwd_claim,
  input logic              dn_fwd_io,
  input logic [FULL_W-1:0] dn_fwd_addr,
  input win_t              win
);
  p_up_strobe_follows_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_fwd_vld |-> $past(up_vld));

  p_dn_strobe_follows_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_fwd_vld |-> $past(dn_vld));

  p_up_dual_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_fwd_vld && (|up_fwd_addr[FULL_W-1:ADDR_W])) |-> !up_fwd_claim);

  p_dn_dual_passed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_fwd_vld && (|dn_fwd_addr[FULL_W-1:ADDR_W])) |-> dn_fwd_claim);

  p_up_mem_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_fwd_vld && up_fwd_claim && !up_fwd_io) |->
      ($past(win.mem_on) && (up_fwd_addr[ADDR_W-1:0] >= $past(win.mem_base))
       && (up_fwd_addr[ADDR_W-1:0] <= $past(win.mem_lim))));

  p_up_io_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_fwd_vld && up_fwd_claim && up_fwd_io) |->
      ($past(win.io_on) && (up_fwd_addr[IO_W-1:0] >= $past(win.io_base))
       && (up_fwd_addr[IO_W-1:0] <= $past(win.io_lim))));

  p_dn_io_kept_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_fwd_vld && !dn_fwd_claim && dn_fwd_io) |->
      ($past(win.io_on) && (dn_fwd_addr[IO_W-1:0] >= $past(win.io_base))
       && (dn_fwd_addr[IO_W-1:0] <= $past(win.io_lim))));
endmodule

bind bwf_filter bwf_filter_chk i_chk (
  .clk(clk), .rst_n(rst_int_n),
  .up_vld(up_vld), .dn_vld(dn_vld),
  .up_fwd_vld(up_fwd_vld), .up_fwd_claim(up_fwd_claim),
  .up_fwd_io(up_fwd_io), .up_fwd_addr(up_fwd_addr),
  .dn_fwd_vld(dn_fwd_vld), .dn_fwd_claim(dn_fwd_claim),
  .dn_fwd_io(dn_fwd_io), .dn_fwd_addr(dn_fwd_addr),
  .win(win)
);

// File: tb/test_bwf_filter.sv
`timescale 1ns/1ps
module test_bwf_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        up_vld = 1'b0, dn_vld = 1'b0;
  logic [1:0]  up_kind = 2'd0, dn_kind = 2'd0;
  logic [31:0] up_addr = '0, dn_addr = '0;
  logic        up_fwd_vld, up_fwd_claim, up_fwd_io;
  logic        dn_fwd_vld, dn_fwd_claim, dn_fwd_io;
  logic [63:0] up_fwd_addr, dn_fwd_addr;

  int n_chk = 0;
  int n_err = 0;

  // bench model of the windows
  logic [31:0] m_mb = '0, m_ml = '0;
  logic [15:0] m_ib = '0, m_il = '0;
  logic        m_mon = 1'b0, m_ion = 1'b0;

  always #4 clk = ~clk;

  bwf_filter i_bwf_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .up_vld(up_vld), .up_kind(up_kind),
    .up_addr(up_addr), .dn_vld(dn_vld), .dn_kind(dn_kind), .dn_addr(dn_addr),
    .up_fwd_vld(up_fwd_vld), .up_fwd_claim(up_fwd_claim),
    .up_fwd_io(up_fwd_io), .up_fwd_addr(up_fwd_addr),
    .dn_fwd_vld(dn_fwd_vld), .dn_fwd_claim(dn_fwd_claim),
    .dn_fwd_io(dn_fwd_io), .dn_fwd_addr(dn_fwd_addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: m_mb = d;
      2'd1: begin m_ml = d; m_mon = 1'b1; end
      2'd2: m_ib = d[15:0];
      default: begin m_il = d[15:0]; m_ion = 1'b1; end
    endcase
  endtask

  // one single-phase cycle on both ports; outputs valid at return
  task automatic phase(input logic [1:0] k, input logic [31:0] a);
    @(negedge clk);
    up_vld = 1'b1; dn_vld = 1'b1; up_kind = k; dn_kind = k;
    up_addr = a; dn_addr = a;
    @(negedge clk);
    up_vld = 1'b0; dn_vld = 1'b0;
  endtask

  function automatic logic mem_hit(input logic [31:0] a);
    return m_mon && (a >= m_mb) && (a <= m_ml);
  endfunction

  function automatic logic io_hit(input logic [15:0] a);
    return m_ion && (a >= m_ib) && (a <= m_il);
  endfunction

  task automatic mem_case(input logic [31:0] a, input string req);
    phase(2'd0, a);
    chk({req, " up vld"}, 64'(up_fwd_vld), 64'd1);
    chk({req, " up claim"}, 64'(up_fwd_claim), 64'(mem_hit(a)));
    chk({req, " dn claim"}, 64'(dn_fwd_claim), 64'(!mem_hit(a)));
    chk({req, " R8 tag"}, 64'({up_fwd_io, dn_fwd_io}), 64'd0);
    chk({req, " R8 addr"}, up_fwd_addr, {32'd0, a});
  endtask

  task automatic io_case(input logic [31:0] a, input string req);
    phase(2'd2, a);
    chk({req, " up claim"}, 64'(up_fwd_claim), 64'(io_hit(a[15:0])));
    chk({req, " dn claim"}, 64'(dn_fwd_claim), 64'(!io_hit(a[15:0])));
    chk({req, " R8 tag"}, 64'({up_fwd_io, dn_fwd_io, dn_fwd_vld}), 64'd7);
    chk({req, " R3 addr"}, dn_fwd_addr, {48'd0, a[15:0]});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: quiet after reset, windows unarmed
    chk("R1 up vld", 64'(up_fwd_vld), 64'd0);
    chk("R1 dn vld", 64'(dn_fwd_vld), 64'd0);
    mem_case(32'h0, "R1 mem");
    io_case(32'h0, "R1 io");

    // R9: program windows
    wr(2'd0, 32'h100); wr(2'd1, 32'h1FF);
    wr(2'd2, 32'hFFFF_0020); wr(2'd3, 32'h003F);

    // R2 / R4 sweep across both memory boundaries
    for (int a = 32'hF0; a <= 32'h210; a++) mem_case(32'(a), "R2 R4 mem");
    // R3 / R4 sweep across the I/O window
    for (int a = 0; a < 32'h60; a++) io_case(32'(a), "R3 R4 io");
    io_case(32'hABCD_001F, "R3 upper");
    io_case(32'hABCD_0020, "R3 upper");
    io_case(32'hABCD_003F, "R3 upper");
    io_case(32'hABCD_0040, "R3 upper");

    // R5: dual-address cycle, low word inside the window
    @(negedge clk);
    up_vld = 1'b1; dn_vld = 1'b1; up_kind = 2'd1; dn_kind = 2'd1;
    up_addr = 32'h150; dn_addr = 32'h150;
    @(negedge clk);
    chk("R5 no early strobe", 64'({up_fwd_vld, dn_fwd_vld}), 64'd0);
    up_kind = 2'd0; dn_kind = 2'd2; up_addr = 32'h1; dn_addr = 32'h1;
    @(negedge clk);
    up_vld = 1'b0; dn_vld = 1'b0;
    chk("R5 strobes", 64'({up_fwd_vld, dn_fwd_vld}), 64'd3);
    chk("R5 up claim", 64'(up_fwd_claim), 64'd0);
    chk("R5 dn claim", 64'(dn_fwd_claim), 64'd1);
    chk("R5 addr", up_fwd_addr, 64'h1_0000_0150);
    chk("R5 dn addr", dn_fwd_addr, 64'h1_0000_0150);
    @(negedge clk);
    chk("R8 one-cycle strobe", 64'({up_fwd_vld, dn_fwd_vld}), 64'd0);

    // R7: configuration cycle inside the window
    phase(2'd3, 32'h150);
    chk("R7 no strobe", 64'({up_fwd_vld, dn_fwd_vld}), 64'd0);
    mem_case(32'h150, "R7 follow-up");

    // R6: inverted windows, plus single-point I/O window
    wr(2'd0, 32'h200); wr(2'd1, 32'h100);
    wr(2'd2, 32'h33); wr(2'd3, 32'h33);
    for (int a = 32'hF0; a <= 32'h210; a += 4) begin
      mem_case(32'(a), "R6 mem");
      chk("R6 up none", 64'(up_fwd_claim), 64'd0);
    end
    for (int a = 32'h30; a < 32'h37; a++) io_case(32'(a), "R3 point");
    wr(2'd2, 32'h40);
    io_case(32'h33, "R6 io");
    chk("R6 io up none", 64'(up_fwd_claim), 64'd0);

    finish_run();
  end
endmodule